// File: doc/BRIEF.md
# Inclusive Two-Level Line Coherence Controller

This block tracks the coherence state of one cache line that is held in an inclusive pair of caches: a small inner cache (L1) backed by a larger outer cache (L2). The system has one processor and write-back caches. Each event arrives together with the line's current L1 and L2 states, which the surrounding tag logic supplies. There are four kinds of event: a processor read, a processor write, a read by an external agent that has no cache, and a write by such an agent. From the event and the two states, the block works out the new pair of states and an ordered list of downstream actions.

The block then issues those actions one at a time over a request/done handshake. When the last action has been acknowledged, it commits the new states to its state outputs and pulses a completion flag. An event with no action completes in the cycle after it is accepted. An entry pair that can never occur in an inclusive single-processor hierarchy is rejected. Rejection raises an error pulse, issues nothing and leaves the state outputs as they were.

The block moves no data, looks up no tags and knows nothing of bus timing. It only decides what must happen and in which order.

Top module: `mesi_pair_ctrl`

## Requirements
- R1: After a synchronous reset, both state outputs read invalid (00), and `busy`, `act_req`, `ev_done` and `ev_err` are low. State codes: I=00, S=01, E=10, M=11. Event codes: processor read=00, processor write=01, external read=10, external write=11. Action codes: none=0, fill from memory=1, fill L1 from L2=2, write into L2=3, write back to memory=4, invalidate=5.
- R2: A processor read with L1=I and L2=I issues the single action fill-from-memory, and ends with L1=S and L2=E.
- R3: A processor read with L1=I and L2 present issues the single action fill-L1-from-L2. It ends with L1=S when L2=E and L1=E when L2=M, and L2 is unchanged. A processor read that finds L1 present issues no action and changes nothing.
- R4: A processor write with L1=S issues write-into-L2 and ends with L1=E and L2=M. With L1=E it issues no action and ends with L1=M. With L1=M it issues no action and the states stay M/M.
- R5: A processor write with L1=I first fills L1 (from memory when L2=I, from L2 otherwise), then issues write-into-L2, and ends with L1=E and L2=M.
- R6: An external read with L1=M issues write-back-to-memory and ends with L1=S and L2=E.
- R7: An external read with L2=M and L1 in E or I issues write-back-to-memory and ends with L2=E, L1=S if L1 was E and L1=I if L1 was I. An external read with L2 not M issues no action and changes nothing.
- R8: An external write with L2=E invalidates, and ends I/I. With L2=M it issues write-back-to-memory, then invalidate, and ends I/I. With both levels I it issues nothing.
- R9: The committed states never show L2=S, never show L1 present with L2=I, and never show L1=M unless L2=M.
- R10: An entry pair outside the six legal pairs (I/I, I/E, I/M, S/E, E/M, M/M as L1/L2) gives a one-cycle `ev_err` in the cycle after acceptance. No action is issued and both state outputs are unchanged.
- R11: Actions are issued one at a time: `act_req` stays high with a stable `act_code` until `act_done` is sampled. `busy` is high from acceptance until the last acknowledgement. Events presented while busy are ignored. `ev_done` pulses for one cycle in the cycle the new states appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present (taken only when not busy) |
| ev_kind | input | 2 | Event code |
| ev_l1 | input | 2 | Current L1 state of the line |
| ev_l2 | input | 2 | Current L2 state of the line |
| act_done | input | 1 | Downstream acknowledges the current action |
| busy | output | 1 | An accepted event is still issuing actions |
| act_req | output | 1 | An action is being requested |
| act_code | output | 3 | Code of the requested action |
| ev_done | output | 1 | One-cycle completion pulse |
| ev_err | output | 1 | One-cycle illegal-entry pulse |
| l1_state | output | 2 | Committed L1 state |
| l2_state | output | 2 | Committed L2 state |

## Verification
The bench builds the block with `PLAN_DEPTH` = 3, one slot above the two that the longest sequence needs. The step index is therefore not a power-of-two counter that wraps on its own. The padded third slot is present in the plan storage but must never be issued. The bench also holds every request over a stall cycle, so the stability of a held action is observed. During a two-step write it injects an external write, which brings the busy-ignore rule within reach. Illegal entry pairs are sent right after a legal event, so that unchanged outputs can be told apart from reset values.

// File: rtl/mesi_pair_pkg.sv
package mesi_pair_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } lstate_e;

    typedef enum logic [1:0] {
        EV_PRD = 2'b00,
        EV_PWR = 2'b01,
        EV_XRD = 2'b10,
        EV_XWR = 2'b11
    } event_e;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_FILL_MEM = 3'd1,
        ACT_FILL_L1  = 3'd2,
        ACT_WR_L2    = 3'd3,
        ACT_WB_MEM   = 3'd4,
        ACT_INVAL    = 3'd5
    } act_e;

    // Longest action sequence any event can need.
    localparam int unsigned CORE_STEPS = 2;

    typedef struct packed {
        logic       legal;
        logic [1:0] n_steps;
        act_e       first;
        act_e       second;
        lstate_e    l1_next;
        lstate_e    l2_next;
    } plan_t;

    // True for the pairs an inclusive single-processor hierarchy can hold.
    function automatic logic pair_legal(lstate_e l1, lstate_e l2);
        logic ok;
        case (l2)
            ST_I:    ok = (l1 == ST_I);
            ST_E:    ok = (l1 == ST_I) || (l1 == ST_S);
            ST_M:    ok = (l1 == ST_I) || (l1 == ST_E) || (l1 == ST_M);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic plan_t make_plan(event_e ev, lstate_e l1, lstate_e l2);
        plan_t p;
        p.legal   = pair_legal(l1, l2);
        p.n_steps = 2'd0;
        p.first   = ACT_NONE;
        p.second  = ACT_NONE;
        p.l1_next = l1;
        p.l2_next = l2;
        if (p.legal) begin
            case (ev)
                EV_PRD: begin
                    if (l1 == ST_I) begin
                        p.n_steps = 2'd1;
                        if (l2 == ST_I) begin
                            p.first   = ACT_FILL_MEM;
                            p.l1_next = ST_S;
                            p.l2_next = ST_E;
                        end else begin
                            p.first   = ACT_FILL_L1;
                            p.l1_next = (l2 == ST_M) ? ST_E : ST_S;
                        end
                    end
                end
                EV_PWR: begin
                    case (l1)
                        ST_S: begin
                            p.n_steps = 2'd1;
                            p.first   = ACT_WR_L2;
                            p.l1_next = ST_E;
                            p.l2_next = ST_M;
                        end
                        ST_E, ST_M: begin
                            p.l1_next = ST_M;
                        end
                        default: begin
                            p.n_steps = 2'd2;
                            p.first   = (l2 == ST_I) ? ACT_FILL_MEM : ACT_FILL_L1;
                            p.second  = ACT_WR_L2;
                            p.l1_next = ST_E;
                            p.l2_next = ST_M;
                        end
                    endcase
                end
                EV_XRD: begin
                    if (l2 == ST_M) begin
                        p.n_steps = 2'd1;
                        p.first   = ACT_WB_MEM;
                        p.l2_next = ST_E;
                        p.l1_next = (l1 == ST_I) ? ST_I : ST_S;
                    end
                end
                default: begin
                    if (l2 != ST_I) begin
                        if (l2 == ST_M) begin
                            p.n_steps = 2'd2;
                            p.first   = ACT_WB_MEM;
                            p.second  = ACT_INVAL;
                        end else begin
                            p.n_steps = 2'd1;
                            p.first   = ACT_INVAL;
                        end
                        p.l1_next = ST_I;
                        p.l2_next = ST_I;
                    end
                end
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/mesi_pair_planner.sv
module mesi_pair_planner
    import mesi_pair_pkg::*;
#(
    parameter int unsigned PLAN_DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(PLAN_DEPTH + 1)
) (
    input  event_e                    ev_kind,
    input  lstate_e                   l1_in,
    input  lstate_e                   l2_in,
    output logic                      legal,
    output logic [CNT_W-1:0]          n_steps,
    output act_e [PLAN_DEPTH-1:0]     steps,
    output lstate_e                   l1_next,
    output lstate_e                   l2_next
);

    plan_t plan;

    always_comb begin
        plan = make_plan(ev_kind, l1_in, l2_in);
    end

    assign legal   = plan.legal;
    assign n_steps = CNT_W'(plan.n_steps);
    assign l1_next = plan.l1_next;
    assign l2_next = plan.l2_next;

    // Slots above the core sequence length are padded with no-op codes.
    for (genvar g = 0; g < PLAN_DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_first
            assign steps[g] = plan.first;
        end else if (g == 1) begin : g_second
            assign steps[g] = plan.second;
        end else begin : g_pad
            assign steps[g] = ACT_NONE;
        end
    end

endmodule

// File: rtl/mesi_pair_seq.sv
module mesi_pair_seq
    import mesi_pair_pkg::*;
#(
    parameter int unsigned PLAN_DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(PLAN_DEPTH + 1),
    localparam int unsigned IDX_W = $clog2(PLAN_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_valid,
    input  logic                  legal,
    input  logic [CNT_W-1:0]      n_steps,
    input  act_e [PLAN_DEPTH-1:0] steps,
    input  lstate_e               l1_next,
    input  lstate_e               l2_next,
    input  logic                  act_done,
    output logic                  busy,
    output logic                  act_req,
    output act_e                  act_code,
    output logic                  ev_done,
    output logic                  ev_err,
    output lstate_e               l1_state,
    output lstate_e               l2_state
);

    typedef enum logic {SQ_IDLE, SQ_RUN} seq_e;

    seq_e                  sq_q;
    act_e [PLAN_DEPTH-1:0] plan_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      idx_q;
    lstate_e               l1_pend_q;
    lstate_e               l2_pend_q;
    logic                  last_step;

    assign busy      = (sq_q == SQ_RUN);
    assign act_req   = busy;
    assign act_code  = busy ? plan_q[idx_q] : ACT_NONE;
    assign last_step = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q      <= SQ_IDLE;
            plan_q    <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            l1_pend_q <= ST_I;
            l2_pend_q <= ST_I;
            l1_state  <= ST_I;
            l2_state  <= ST_I;
            ev_done   <= 1'b0;
            ev_err    <= 1'b0;
        end else begin
            ev_done <= 1'b0;
            ev_err  <= 1'b0;
            case (sq_q)
                SQ_IDLE: begin
                    if (ev_valid) begin
                        if (!legal) begin
                            ev_err <= 1'b1;
                        end else if (n_steps == '0) begin
                            l1_state <= l1_next;
                            l2_state <= l2_next;
                            ev_done  <= 1'b1;
                        end else begin
                            sq_q      <= SQ_RUN;
                            plan_q    <= steps;
                            cnt_q     <= n_steps;
                            idx_q     <= '0;
                            l1_pend_q <= l1_next;
                            l2_pend_q <= l2_next;
                        end
                    end
                end
                default: begin
                    if (act_done) begin
                        if (last_step) begin
                            sq_q     <= SQ_IDLE;
                            l1_state <= l1_pend_q;
                            l2_state <= l2_pend_q;
                            ev_done  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R11: a request without acknowledgement is held with the same code.
    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (act_req && !act_done) |=> (act_req && $stable(act_code)));

    // R11: a live request always carries a real action.
    assert_req_code_R11: assert property (@(posedge clk) disable iff (rst)
        act_req |-> (act_code != ACT_NONE));

    // R11: completion is reported only once the sequencer is free.
    assert_done_free_R11: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> !busy);

    // R10: a rejected entry leaves the committed states alone.
    assert_err_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        ev_err |-> ($stable(l1_state) && $stable(l2_state) && !act_req));

endmodule

// File: rtl/mesi_pair_ctrl.sv
module mesi_pair_ctrl
    import mesi_pair_pkg::*;
#(
    parameter int unsigned PLAN_DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(PLAN_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_valid,
    input  logic [1:0] ev_kind,
    input  logic [1:0] ev_l1,
    input  logic [1:0] ev_l2,
    input  logic       act_done,
    output logic       busy,
    output logic       act_req,
    output logic [2:0] act_code,
    output logic       ev_done,
    output logic       ev_err,
    output logic [1:0] l1_state,
    output logic [1:0] l2_state
);

    initial begin
        if (PLAN_DEPTH < CORE_STEPS) $error("PLAN_DEPTH below the longest sequence");
    end

    logic                  p_legal;
    logic [CNT_W-1:0]      p_cnt;
    act_e [PLAN_DEPTH-1:0] p_steps;
    lstate_e               p_l1;
    lstate_e               p_l2;
    act_e                  code_e;
    lstate_e               l1_e;
    lstate_e               l2_e;

    mesi_pair_planner #(.PLAN_DEPTH(PLAN_DEPTH)) u_plan (
        .ev_kind (event_e'(ev_kind)),
        .l1_in   (lstate_e'(ev_l1)),
        .l2_in   (lstate_e'(ev_l2)),
        .legal   (p_legal),
        .n_steps (p_cnt),
        .steps   (p_steps),
        .l1_next (p_l1),
        .l2_next (p_l2)
    );

    mesi_pair_seq #(.PLAN_DEPTH(PLAN_DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .legal    (p_legal),
        .n_steps  (p_cnt),
        .steps    (p_steps),
        .l1_next  (p_l1),
        .l2_next  (p_l2),
        .act_done (act_done),
        .busy     (busy),
        .act_req  (act_req),
        .act_code (code_e),
        .ev_done  (ev_done),
        .ev_err   (ev_err),
        .l1_state (l1_e),
        .l2_state (l2_e)
    );

    assign act_code = code_e;
    assign l1_state = l1_e;
    assign l2_state = l2_e;

    // R9: the outer level never holds the shared state.
    assert_l2_not_s_R9: assert property (@(posedge clk) disable iff (rst)
        l2_state != ST_S);

    // R9: inclusion, the inner copy needs an outer copy.
    assert_inclusive_R9: assert property (@(posedge clk) disable iff (rst)
        (l1_state != ST_I) |-> (l2_state != ST_I));

    // R9: a modified inner copy needs a modified outer copy.
    assert_m_pair_R9: assert property (@(posedge clk) disable iff (rst)
        (l1_state == ST_M) |-> (l2_state == ST_M));

    // R11: committed states do not move while actions are in flight.
    assert_hold_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(l1_state) && $stable(l2_state)));

endmodule

// File: tb/mesi_pair_ctrl_tb.sv
module mesi_pair_ctrl_tb;

    localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;
    localparam logic [1:0] KPR = 2'b00, KPW = 2'b01, KXR = 2'b10, KXW = 2'b11;
    localparam logic [2:0] AN = 3'd0, AFM = 3'd1, AFL = 3'd2, AWL = 3'd3,
                           AWB = 3'd4, AIV = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_kind = 2'b00;
    logic [1:0] ev_l1 = 2'b00;
    logic [1:0] ev_l2 = 2'b00;
    logic       act_done = 1'b0;
    logic       busy, act_req, ev_done, ev_err;
    logic [2:0] act_code;
    logic [1:0] l1_state, l2_state;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mesi_pair_ctrl #(.PLAN_DEPTH(3)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_l1(ev_l1), .ev_l2(ev_l2), .act_done(act_done), .busy(busy),
        .act_req(act_req), .act_code(act_code), .ev_done(ev_done),
        .ev_err(ev_err), .l1_state(l1_state), .l2_state(l2_state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Runs one legal event; a1 is used only when n == 2.
    task automatic run_ev(input string req, input logic [1:0] kind, input logic [1:0] l1,
                          input logic [1:0] l2, input int n, input logic [2:0] a0,
                          input logic [2:0] a1, input logic [1:0] e1, input logic [1:0] e2,
                          input bit intrude);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = kind; ev_l1 = l1; ev_l2 = l2;
        @(negedge clk);
        ev_valid = 1'b0;
        chk(req, "err", int'(ev_err), 0);
        if (n == 0) begin
            chk(req, "busy", int'(busy), 0);
            chk(req, "req", int'(act_req), 0);
        end
        for (int i = 0; i < n; i++) begin
            chk(req, "busy", int'(busy), 1);
            chk(req, "req", int'(act_req), 1);
            chk(req, "code", int'(act_code), int'((i == 0) ? a0 : a1));
            chk(req, "early done", int'(ev_done), 0);
            if (intrude && i == 0) begin
                ev_valid = 1'b1; ev_kind = KXW; ev_l1 = SM; ev_l2 = SM;
            end
            @(negedge clk);
            ev_valid = 1'b0;
            chk(req, "held code", int'(act_code), int'((i == 0) ? a0 : a1));
            act_done = 1'b1;
            @(negedge clk);
            act_done = 1'b0;
        end
        chk(req, "done", int'(ev_done), 1);
        chk(req, "busy after", int'(busy), 0);
        chk(req, "l1", int'(l1_state), int'(e1));
        chk(req, "l2", int'(l2_state), int'(e2));
        @(negedge clk);
        chk(req, "done pulse", int'(ev_done), 0);
        chk(req, "idle req", int'(act_req), 0);
    endtask

    // Presents an illegal entry pair; outputs must stay at e1/e2.
    task automatic run_bad(input logic [1:0] kind, input logic [1:0] l1, input logic [1:0] l2,
                           input logic [1:0] e1, input logic [1:0] e2);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = kind; ev_l1 = l1; ev_l2 = l2;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R10", "err", int'(ev_err), 1);
        chk("R10", "req", int'(act_req), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "done", int'(ev_done), 0);
        chk("R10", "l1", int'(l1_state), int'(e1));
        chk("R10", "l2", int'(l2_state), int'(e2));
        @(negedge clk);
        chk("R10", "err pulse", int'(ev_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "l1", int'(l1_state), int'(SI));
        chk("R1", "l2", int'(l2_state), int'(SI));
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "req", int'(act_req), 0);
        chk("R1", "done", int'(ev_done), 0);
        chk("R1", "err", int'(ev_err), 0);

        run_ev("R2", KPR, SI, SI, 1, AFM, AN, SS, SE, 1'b0);
        run_ev("R3", KPR, SI, SE, 1, AFL, AN, SS, SE, 1'b0);
        run_ev("R3", KPR, SI, SM, 1, AFL, AN, SE, SM, 1'b0);
        run_ev("R3", KPR, SS, SE, 0, AN, AN, SS, SE, 1'b0);
        run_ev("R3", KPR, SM, SM, 0, AN, AN, SM, SM, 1'b0);

        run_ev("R4", KPW, SS, SE, 1, AWL, AN, SE, SM, 1'b0);
        run_ev("R4", KPW, SE, SM, 0, AN, AN, SM, SM, 1'b0);
        run_ev("R4", KPW, SM, SM, 0, AN, AN, SM, SM, 1'b0);

        run_ev("R5", KPW, SI, SI, 2, AFM, AWL, SE, SM, 1'b0);
        run_ev("R5", KPW, SI, SE, 2, AFL, AWL, SE, SM, 1'b0);
        run_ev("R5", KPW, SI, SM, 2, AFL, AWL, SE, SM, 1'b0);

        run_ev("R6", KXR, SM, SM, 1, AWB, AN, SS, SE, 1'b0);
        run_ev("R7", KXR, SE, SM, 1, AWB, AN, SS, SE, 1'b0);
        run_ev("R7", KXR, SI, SM, 1, AWB, AN, SI, SE, 1'b0);
        run_ev("R7", KXR, SS, SE, 0, AN, AN, SS, SE, 1'b0);

        run_ev("R8", KXW, SS, SE, 1, AIV, AN, SI, SI, 1'b0);
        run_ev("R8", KXW, SM, SM, 2, AWB, AIV, SI, SI, 1'b0);
        run_ev("R8", KXW, SI, SE, 1, AIV, AN, SI, SI, 1'b0);
        run_ev("R8", KXW, SI, SI, 0, AN, AN, SI, SI, 1'b0);

        // R10: set a non-reset state first, then offer impossible pairs.
        run_ev("R10", KPR, SI, SI, 1, AFM, AN, SS, SE, 1'b0);
        run_bad(KPR, SS, SS, SS, SE);
        run_bad(KPW, SE, SE, SS, SE);
        run_bad(KXW, SM, SE, SS, SE);
        run_bad(KXR, SS, SM, SS, SE);
        run_bad(KPR, SE, SI, SS, SE);

        // R11: an external write offered while busy must not disturb the write.
        run_ev("R11", KPW, SI, SI, 2, AFM, AWL, SE, SM, 1'b1);

        // R9 committed pair remains legal after the sequence above.
        chk("R9", "l2 not S", int'(l2_state != SS), 1);

        summary();
        $finish;
    end

endmodule